// File: doc/BRIEF.md
# Averaging Half-Bridge Leg Voltage Source

This block stands in for one half-bridge leg of a power inverter inside a fixed-step, real-time plant model. The ideal switches are not modelled. For every simulation step the block instead produces the mean leg voltage over that step and acts as a controlled voltage source. Each step supplies three things: the DC-link voltage, the fraction of the step during which the high-side gate was on, and the fraction during which the low-side gate was on. These fractions are the time-stamped gate captures, normalised to the step. Because both fractions are used, a short gate pulse still contributes in proportion to its width. This keeps the leg linear even when the carrier period is only a few steps long.

The part of the step where neither gate is on is the dead time. During that interval the leg voltage depends on which freewheel diode conducts, and that in turn depends on the polarity of the load current. A current flowing out of the leg puts the leg at the low rail. A current flowing into the leg puts it at the high rail.

A shutdown input forces both gates off for the whole step, regardless of the ratio inputs. When shutdown is set and the load current is zero, no device conducts. The block then reports a high-impedance code. If the gate fractions overlap (shoot-through), the block raises an error flag and saturates its output.

Top module: `sw_leg_avg`

## Requirements
- R1: After reset, `vleg_o` is 0 and `valid_o`, `shoot_o` and `tri_o` are all low.
- R2: A step strobe that `step_i` carries into rising edge E0 gives a result that appears after rising edge E0+1. `valid_o` is high for exactly that one cycle. `valid_o` is never high without such a strobe.
- R3: Ratios are unsigned, and the value 2^RW means the whole step. In normal mode, with positive load current (`cur_neg_i` = 0), the output is floor(vdc × hi / 2^RW). The low-side ratio does not change this value.
- R4: In normal mode with negative load current (`cur_neg_i` = 1, `cur_zero_i` = 0), the dead-time fraction 2^RW − hi − lo is added to the high-side fraction. The output is floor(vdc × (2^RW − lo) / 2^RW).
- R5: `cur_zero_i` = 1 overrides `cur_neg_i`. In normal mode, zero current is treated as non-negative, so the dead-time fraction contributes 0 V.
- R6: In normal mode, if hi + lo > 2^RW, then `shoot_o` = 1 and the output equals vdc. If hi + lo = 2^RW exactly, `shoot_o` = 0.
- R7: With `shutdown_i` = 1, both ratios are ignored and `shoot_o` = 0. The output is vdc for negative current and 0 for positive current.
- R8: With `shutdown_i` = 1 and `cur_zero_i` = 1, `tri_o` = 1 and `vleg_o` holds the all-ones code while `valid_o` is asserted. `tri_o` is never set together with `shoot_o`.
- R9: Between results, `vleg_o`, `shoot_o` and `tri_o` hold their last values. Input changes that arrive without a strobe have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| step_i | input | 1 | One-cycle strobe that starts a simulation step |
| vdc_i | input | VW | DC-link voltage, unsigned |
| hi_ratio_i | input | RW+1 | High-side on fraction, 2^RW = full step |
| lo_ratio_i | input | RW+1 | Low-side on fraction, 2^RW = full step |
| cur_neg_i | input | 1 | Load current is negative (flowing into the leg) |
| cur_zero_i | input | 1 | Load current is zero |
| shutdown_i | input | 1 | Pulse shutdown: both gates forced off |
| vleg_o | output | VW | Averaged leg voltage, or all ones when high impedance |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| shoot_o | output | 1 | Shoot-through error for the current result |
| tri_o | output | 1 | High-impedance code for the current result |

## Verification
The bench builds the block with VW = 12 and RW = 6, so a full step is only 64 counts. At that scale, random ratio pairs land on the exact-sum boundary of 64 and on overlapping sums often. Random voltages also reach the top of the 12-bit range, so full-scale products and floor truncation are exercised on every kind of result. Directed steps cover shutdown with each current polarity, zero current in both modes, and inputs that change with no strobe.

// File: rtl/sw_leg_avg.sv
module sw_leg_avg #(
  parameter int VW = 16,
  parameter int RW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [VW-1:0] vdc_i,
  input  logic [RW:0]   hi_ratio_i,
  input  logic [RW:0]   lo_ratio_i,
  input  logic          cur_neg_i,
  input  logic          cur_zero_i,
  input  logic          shutdown_i,
  output logic [VW-1:0] vleg_o,
  output logic          valid_o,
  output logic          shoot_o,
  output logic          tri_o
);
  localparam int PW = VW + RW + 1;
  localparam logic [RW+1:0] FULL = (RW+2)'(1) << RW;

  logic          neg;
  logic [RW+1:0] sum, dead, eff;
  logic          over;

  assign neg  = cur_neg_i & ~cur_zero_i;
  assign sum  = {1'b0, hi_ratio_i} + {1'b0, lo_ratio_i};
  assign over = ~shutdown_i & (sum > FULL);
  assign dead = FULL - sum;

  always_comb begin
    if (shutdown_i)  eff = neg ? FULL : '0;
    else if (over)   eff = FULL;
    else             eff = {1'b0, hi_ratio_i} + (neg ? dead : '0);
  end

  logic          s1_vld, s1_over, s1_tri;
  logic [RW:0]   s1_eff;
  logic [VW-1:0] s1_vdc;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_over <= 1'b0;
      s1_tri  <= 1'b0;
      s1_eff  <= '0;
      s1_vdc  <= '0;
    end else begin
      s1_vld <= step_i;
      if (step_i) begin
        s1_over <= over;
        s1_tri  <= shutdown_i & cur_zero_i;
        s1_eff  <= eff[RW:0];
        s1_vdc  <= vdc_i;
      end
    end
  end

  logic [PW-1:0] prod;
  assign prod = PW'(s1_vdc) * PW'(s1_eff);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      vleg_o  <= '0;
      valid_o <= 1'b0;
      shoot_o <= 1'b0;
      tri_o   <= 1'b0;
    end else begin
      valid_o <= s1_vld;
      if (s1_vld) begin
        vleg_o  <= s1_tri ? '1 : prod[VW+RW-1:RW];
        shoot_o <= s1_over;
        tri_o   <= s1_tri;
      end
    end
  end
endmodule

// File: rtl/sw_leg_avg_chk.sv
module sw_leg_avg_chk #(
  parameter int VW = 16,
  parameter int RW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          step_i,
  input logic [VW-1:0] vdc_i,
  input logic [VW-1:0] vleg_o,
  input logic          valid_o,
  input logic          shoot_o,
  input logic          tri_o
);
  logic [1:0] age;
  always_ff @(posedge clk_i) begin
    if (!rst_ni)       age <= '0;
    else if (age != 3) age <= age + 2'd1;
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> ##1 valid_o);

  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 3 && valid_o) |-> $past(step_i, 2));

  p_shoot_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 3 && valid_o && shoot_o) |-> vleg_o == $past(vdc_i, 2));

  p_tri_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tri_o |-> (vleg_o == '1 && !shoot_o));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age != 0 && !valid_o) |-> ($stable(vleg_o) && $stable(shoot_o) && $stable(tri_o)));
endmodule

bind sw_leg_avg sw_leg_avg_chk #(.VW(VW), .RW(RW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .vdc_i(vdc_i),
  .vleg_o(vleg_o), .valid_o(valid_o), .shoot_o(shoot_o), .tri_o(tri_o)
);

// File: tb/sw_leg_avg_bench.sv
module sw_leg_avg_bench;
  localparam int VW = 12;
  localparam int RW = 6;
  localparam int FS = 1 << RW;
  localparam int CLK_PERIOD = 10;

  logic          clk = 0, rst_n = 0, step = 0;
  logic [VW-1:0] vdc = 0;
  logic [RW:0]   hi = 0, lo = 0;
  logic          neg = 0, zero = 0, sd = 0;
  logic [VW-1:0] vleg;
  logic          valid, shoot, tri_s;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_leg_avg #(.VW(VW), .RW(RW)) u_sw_leg_avg (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .vdc_i(vdc),
    .hi_ratio_i(hi), .lo_ratio_i(lo), .cur_neg_i(neg), .cur_zero_i(zero),
    .shutdown_i(sd), .vleg_o(vleg), .valid_o(valid), .shoot_o(shoot), .tri_o(tri_s)
  );

  task automatic chk(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint exp_v(int v, int h, int l, bit n, bit z, bit s);
    int e;
    if (s) return z ? (1 << VW) - 1 : ((n && !z) ? v : 0);
    if (h + l > FS) return v;
    e = h + ((n && !z) ? FS - h - l : 0);
    return (longint'(v) * e) >> RW;
  endfunction

  function automatic bit exp_shoot(int h, int l, bit s);
    return !s && (h + l > FS);
  endfunction

  task automatic run_step(string req, int v, int h, int l, bit n, bit z, bit s);
    vdc = VW'(v); hi = (RW+1)'(h); lo = (RW+1)'(l); neg = n; zero = z; sd = s;
    step = 1;
    @(negedge clk);
    step = 0;
    chk({req, " R2 no early valid"}, valid, 0);
    @(negedge clk);
    chk({req, " R2 valid"}, valid, 1);
    chk({req, " value"}, vleg, exp_v(v, h, l, n, z, s));
    chk({req, " R6 shoot flag"}, shoot, exp_shoot(h, l, s));
    chk({req, " R8 tri flag"}, tri_s, s && z);
    @(negedge clk);
    chk({req, " R2 one-cycle valid"}, valid, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [VW-1:0] held;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 vleg", vleg, 0);
    chk("R1 valid", valid, 0);
    chk("R1 shoot", shoot, 0);
    chk("R1 tri", tri_s, 0);
    rst_n = 1;
    @(negedge clk);

    run_step("R3 hi only", 3000, 20, 0, 0, 0, 0);
    run_step("R3 lo ignored", 3000, 20, 30, 0, 0, 0);
    run_step("R3 full hi", 4095, 64, 0, 0, 0, 0);
    run_step("R4 neg dead time", 3001, 10, 40, 1, 0, 0);
    run_step("R4 neg all dead", 2500, 0, 0, 1, 0, 0);
    run_step("R5 zero overrides neg", 2500, 10, 20, 1, 1, 0);
    run_step("R6 exact sum", 4000, 30, 34, 1, 0, 0);
    run_step("R6 overlap", 1234, 40, 30, 0, 0, 0);
    run_step("R6 overlap huge", 4095, 127, 127, 1, 0, 0);
    run_step("R7 shutdown neg", 1777, 127, 127, 1, 0, 1);
    run_step("R7 shutdown pos", 1777, 50, 0, 0, 0, 1);
    run_step("R8 shutdown zero", 1777, 50, 10, 1, 1, 1);
    run_step("R5 zero normal", 900, 5, 5, 0, 1, 0);

    held = vleg;
    vdc = 12; hi = 64; lo = 0; neg = 1; zero = 0; sd = 1;
    repeat (5) @(negedge clk);
    chk("R9 hold vleg", vleg, held);
    chk("R9 hold valid", valid, 0);
    chk("R9 hold shoot", shoot, 0);

    for (int i = 0; i < 400; i++) begin
      int v, h, l;
      bit n, z, s;
      v = int'($urandom % (1 << VW));
      h = int'($urandom % (FS + 1));
      l = ($urandom % 4 == 0) ? int'($urandom % (2 * FS)) : int'($urandom % (FS + 1 - h));
      if (l > 2 * FS - 1) l = 2 * FS - 1;
      n = 1'($urandom);
      z = ($urandom % 8 == 0);
      s = ($urandom % 6 == 0);
      run_step("R3/R4/R6/R7 random", v, h, l, n, z, s);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule